// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction Control

A six-bit general-purpose I/O port that sits on a simple register bus. Each pin has an output latch bit and a direction bit. A direction bit of 1 makes the pin an input (driver off). A direction bit of 0 puts the latch bit on the pin. Reads of the data register return the pin levels after a two-flop synchronizer, not the latch contents. Software therefore does bit-set and bit-clear as read-modify-write through the live pin levels.

Bit 4 is open-drain. When enabled as an output, it can only pull the pin low. Its synchronized level is also passed out as a clock for an external timer. A per-pin analog-select input comes from the converter configuration. It forces the digital read of that pin to 0, but it does not change how the direction bit controls the driver.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 0x3F and every `pin_oe` bit is 0.
- R2: For a push-pull pin (every bit except 4), `pin_oe` equals the inverse of its direction bit, and while enabled `pin_out` equals its latch bit.
- R3: A direction register read returns the stored direction bits in bits 5:0 and 0 in bits 7:6, whatever value was written there.
- R4: A data register read returns each pin's `pin_in` level delayed by two clock edges; a change in `pin_in` is not visible after one edge.
- R5: A data register write loads bits 5:0 into the output latch on the next edge, even for pins configured as inputs. The value shows on the pin once the pin's direction is cleared.
- R6: Bit 4 drives (`pin_oe[4]` = 1) only when its direction bit is 0 and its latch bit is 0, and `pin_out[4]` is never 1 while driving.
- R7: A data read returns 0 for every pin whose `ana_sel` bit is 1. `ana_sel` has no effect on `pin_oe`.
- R8: `tmr_clk` equals the two-stage synchronized level of pin 4, independent of `ana_sel` and of the direction bit.
- R9: `bus_rdata` is 0 when neither read enable is high. When both are high, the data register read wins.
- R10: A bit-set done as read, OR, write through the bus copies the external levels of the other input pins into their latch bits.
- R11: A data register read returns 0 in bits 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_data | input | 1 | Write strobe for the output latch |
| bus_wr_dir | input | 1 | Write strobe for the direction register |
| bus_rd_data | input | 1 | Read enable, pin levels |
| bus_rd_dir | input | 1 | Read enable, direction register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 6 | Sampled pad levels |
| ana_sel | input | 6 | Per-pin analog selection |
| pin_out | output | 6 | Output value to pads |
| pin_oe | output | 6 | Output enable to pads |
| tmr_clk | output | 1 | Synchronized pin-4 level for a timer |

## Verification
The bench models the pads so that a driven pin reads back its own output, and an undriven pin reads an external level. Each scenario then relies on the read path seeing the pin, not the latch. A read that returned the latch would fail the input-read and read-modify-write scenarios, because there the two differ. Reading one edge after a level change catches a synchronizer that is too short. Driving bit 4 with latch 1 and then latch 0 catches an open-drain bit that drives high. Analog pins held high, with their direction bit cleared, catch both a read mask left out and a mask wrongly applied to the output enable.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    RSRC_NONE = 2'd0,
    RSRC_PINS = 2'd1,
    RSRC_DIR  = 2'd2
  } rd_src_e;

  function automatic rd_src_e pick_src(input logic want_pins, input logic want_dir);
    if (want_pins)     return RSRC_PINS;
    else if (want_dir) return RSRC_DIR;
    else               return RSRC_NONE;
  endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_lat,
  input  logic         wr_dir,
  input  logic [W-1:0] wval,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] dir_q
);
  // Output latch: contents undefined until first write.
  always_ff @(posedge clk) begin
    if (wr_lat) lat_q <= wval;
  end

  // Direction: all inputs after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '1;
    else if (wr_dir) dir_q <= wval;
  end
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_drive.sv
module gpio_port_drive #(
  parameter int           W       = 6,
  parameter logic [W-1:0] OD_MASK = 6'b010000
) (
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] dir_q,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (OD_MASK[i]) begin : g_od
      // Open drain: only a low level is ever driven.
      assign pad_oe[i]  = ~dir_q[i] & ~lat_q[i];
      assign pad_out[i] = 1'b0;
    end else begin : g_pp
      assign pad_oe[i]  = ~dir_q[i];
      assign pad_out[i] = lat_q[i] & ~dir_q[i];
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int           W        = 6,
  parameter int           BW       = gpio_port_pkg::BUS_W,
  parameter int           STAGES   = 2,
  parameter int           TMR_BIT  = 4,
  parameter logic [W-1:0] OD_MASK  = 6'b010000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr_data,
  input  logic          bus_wr_dir,
  input  logic          bus_rd_data,
  input  logic          bus_rd_dir,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic [W-1:0]  pin_in,
  input  logic [W-1:0]  ana_sel,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          tmr_clk
);
  import gpio_port_pkg::*;

  localparam int PAD_HI = BW - W;

  logic [W-1:0] lat_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] pin_sync;
  logic [W-1:0] pin_digital;
  rd_src_e      rd_src;
  logic         unused_hi;

  assign unused_hi = ^bus_wdata[BW-1:W];

  function automatic logic [BW-1:0] widen(input logic [W-1:0] v);
    return {{PAD_HI{1'b0}}, v};
  endfunction

  gpio_port_regs #(.W(W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_lat (bus_wr_data),
    .wr_dir (bus_wr_dir),
    .wval   (bus_wdata[W-1:0]),
    .lat_q  (lat_q),
    .dir_q  (dir_q)
  );

  gpio_port_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_port_drive #(.W(W), .OD_MASK(OD_MASK)) u_drive (
    .lat_q   (lat_q),
    .dir_q   (dir_q),
    .pad_out (pin_out),
    .pad_oe  (pin_oe)
  );

  assign pin_digital = pin_sync & ~ana_sel;
  assign tmr_clk     = pin_sync[TMR_BIT];
  assign rd_src      = pick_src(bus_rd_data, bus_rd_dir);

  always_comb begin
    unique case (rd_src)
      RSRC_PINS: bus_rdata = widen(pin_digital);
      RSRC_DIR:  bus_rdata = widen(dir_q);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int           W       = 6,
  parameter int           BW      = 8,
  parameter int           TMR_BIT = 4,
  parameter logic [W-1:0] OD_MASK = 6'b010000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr_data,
  input logic          bus_rd_data,
  input logic          bus_rd_dir,
  input logic [BW-1:0] bus_wdata,
  input logic [BW-1:0] bus_rdata,
  input logic [W-1:0]  pin_in,
  input logic [W-1:0]  ana_sel,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe,
  input logic          tmr_clk,
  input logic [W-1:0]  lat_q,
  input logic [W-1:0]  dir_q
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_DIR_AFTER_RESET: assert property (@(posedge clk) $rose(rst_n) |-> (dir_q == '1) && (pin_oe == '0)); // R1
  AST_PP_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) ((pin_oe ^ ~dir_q) & ~OD_MASK) == '0); // R2
  AST_DIR_READ_TOP: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd_dir && !bus_rd_data) |-> bus_rdata[BW-1:W] == '0); // R3
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n) bus_wr_data |=> lat_q == $past(bus_wdata[W-1:0])); // R5
  AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (pin_oe & OD_MASK & (pin_out | lat_q)) == '0); // R6
  AST_ANALOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n) bus_rd_data |-> (bus_rdata[W-1:0] & ana_sel) == '0); // R7
  AST_TMR_SYNC: assert property (@(posedge clk) disable iff (!rst_n) (since_rst >= 2'd2) |-> tmr_clk == $past(pin_in[TMR_BIT], 2)); // R8
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n) (!bus_rd_data && !bus_rd_dir) |-> bus_rdata == '0); // R9
  AST_DATA_READ_TOP: assert property (@(posedge clk) disable iff (!rst_n) bus_rd_data |-> bus_rdata[BW-1:W] == '0); // R11
endmodule

bind gpio_port gpio_port_chk #(.W(W), .BW(BW), .TMR_BIT(TMR_BIT), .OD_MASK(OD_MASK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr_data (bus_wr_data),
  .bus_rd_data (bus_rd_data),
  .bus_rd_dir  (bus_rd_dir),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .pin_in      (pin_in),
  .ana_sel     (ana_sel),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .tmr_clk     (tmr_clk),
  .lat_q       (lat_q),
  .dir_q       (dir_q)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr_data = 1'b0;
  logic       bus_wr_dir = 1'b0;
  logic       bus_rd_data = 1'b0;
  logic       bus_rd_dir = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] pin_in;
  logic [5:0] ana_sel = '0;
  logic [5:0] pin_out;
  logic [5:0] pin_oe;
  logic       tmr_clk;
  logic [5:0] ext_lvl = '0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  // Pad model: a driven pin reads its own output, else the external level.
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_lvl);

  gpio_port uut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_data(bus_wr_data), .bus_wr_dir(bus_wr_dir),
    .bus_rd_data(bus_rd_data), .bus_rd_dir(bus_rd_dir),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .ana_sel(ana_sel),
    .pin_out(pin_out), .pin_oe(pin_oe), .tmr_clk(tmr_clk)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_port(input logic [7:0] v);
    @(negedge clk); bus_wdata = v; bus_wr_data = 1'b1;
    @(negedge clk); bus_wr_data = 1'b0;
  endtask

  task automatic wr_dirreg(input logic [7:0] v);
    @(negedge clk); bus_wdata = v; bus_wr_dir = 1'b1;
    @(negedge clk); bus_wr_dir = 1'b0;
  endtask

  task automatic rd(input logic pins, input logic dirr, output logic [7:0] v);
    @(negedge clk); bus_rd_data = pins; bus_rd_dir = dirr;
    #1 v = bus_rdata;
    bus_rd_data = 1'b0; bus_rd_dir = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, 1'b1, v);
    check("R1 dir after reset", v, 8'h3F);
    check("R1 oe after reset", {2'b0, pin_oe}, 8'h00);
    wr_port(8'h00);
  endtask

  task automatic t_dir_read();
    logic [7:0] v;
    wr_dirreg(8'hFF);
    rd(1'b0, 1'b1, v);
    check("R3 dir top bits zero", v, 8'h3F);
    wr_dirreg(8'hC5);
    rd(1'b0, 1'b1, v);
    check("R3 dir stored bits", v, 8'h05);
    wr_dirreg(8'h3F);
  endtask

  task automatic t_input_read();
    logic [7:0] v;
    @(negedge clk); ext_lvl = 6'h2A;
    settle();
    rd(1'b1, 1'b0, v);
    check("R4 read pins not latch", v, 8'h2A);
    @(negedge clk); ext_lvl = 6'h15;
    rd(1'b1, 1'b0, v);
    check("R4 one edge still old", v, 8'h2A);
    rd(1'b1, 1'b0, v);
    check("R4 two edges new", v, 8'h15);
    @(negedge clk); ext_lvl = 6'h3F;
    settle();
    rd(1'b1, 1'b0, v);
    check("R11 data top bits zero", v, 8'h3F);
  endtask

  task automatic t_write_latch();
    @(negedge clk); ext_lvl = 6'h00;
    wr_port(8'hFF);
    check("R5 input pin stays undriven", {2'b0, pin_oe}, 8'h00);
    wr_dirreg(8'h00);
    #1;
    check("R2 R5 oe with latch ones", {2'b0, pin_oe}, 8'h2F);
    check("R5 latched value on pins", {2'b0, pin_out & pin_oe}, 8'h2F);
    check("R6 od bit floats for latch 1", {7'b0, pin_oe[4]}, 8'h00);
    wr_dirreg(8'h3F);
  endtask

  task automatic t_open_drain();
    logic [7:0] v;
    @(negedge clk); ext_lvl = 6'h3F;
    wr_port(8'h00);
    wr_dirreg(8'h00);
    #1;
    check("R6 od drives for latch 0", {2'b0, pin_oe}, 8'h3F);
    check("R6 od output low", {7'b0, pin_out[4]}, 8'h00);
    settle();
    rd(1'b1, 1'b0, v);
    check("R4 read driven pins", v, 8'h00);
    wr_dirreg(8'h3F);
  endtask

  task automatic t_analog();
    logic [7:0] v;
    @(negedge clk); ext_lvl = 6'h3F; ana_sel = 6'h05;
    settle();
    rd(1'b1, 1'b0, v);
    check("R7 analog pins read zero", v, 8'h3A);
    wr_port(8'h01);
    wr_dirreg(8'h3E);
    #1;
    check("R7 direction governs analog pin", {2'b0, pin_oe}, 8'h01);
    wr_dirreg(8'h3F);
    @(negedge clk); ana_sel = 6'h00;
  endtask

  task automatic t_tmr();
    logic [7:0] v;
    @(negedge clk); ana_sel = 6'h10; ext_lvl = 6'h00;
    settle();
    check("R8 tmr low", {7'b0, tmr_clk}, 8'h00);
    @(negedge clk); ext_lvl = 6'h10;
    @(negedge clk);
    check("R8 tmr one edge old", {7'b0, tmr_clk}, 8'h00);
    @(negedge clk);
    check("R8 tmr follows pin", {7'b0, tmr_clk}, 8'h01);
    rd(1'b1, 1'b0, v);
    check("R7 analog bit4 reads zero", v, 8'h00);
    @(negedge clk); ana_sel = 6'h00;
  endtask

  task automatic t_bus_idle();
    logic [7:0] v;
    @(negedge clk); ext_lvl = 6'h2B;
    settle();
    rd(1'b0, 1'b0, v);
    check("R9 no enable reads zero", v, 8'h00);
    rd(1'b1, 1'b1, v);
    check("R9 data read wins", v, 8'h2B);
  endtask

  task automatic t_rmw();
    logic [7:0] v;
    wr_dirreg(8'h3F);
    wr_port(8'h00);
    @(negedge clk); ext_lvl = 6'h01;
    settle();
    rd(1'b1, 1'b0, v);
    wr_port(v | 8'h04);
    @(negedge clk); ext_lvl = 6'h00;
    wr_dirreg(8'h3A);
    #1;
    check("R10 rmw oe", {2'b0, pin_oe}, 8'h05);
    check("R10 rmw copied input level", {2'b0, pin_out & 6'h05}, 8'h05);
    wr_dirreg(8'h3F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir_read();
    t_input_read();
    t_write_latch();
    t_open_drain();
    t_analog();
    t_tmr();
    t_bus_idle();
    t_rmw();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule